// File: doc/BRIEF.md
# Serial Frame and Byte Aligner

This block watches a serial bit stream, one bit per cycle in which the bit-rate enable is high, for the 48-bit line framing word: three A1 bytes followed at once by three A2 bytes. When a search is armed and the word turns up at any bit position, the block moves its byte boundary to that position. It then reports the new boundary as a bit offset, restarts its byte strobe from there and raises a frame pulse for one byte period.

A rising edge on the out-of-frame input arms the search. The search stays armed while that input is high. Once a word has been found and the input is low, the search is disarmed and the boundary is frozen. While frozen, the frame pulse still marks framing words, but only those that end exactly on the locked boundary. A loopback select swaps a second serial source in place of the line input.

Top module: `sonet_frame_aligner`

## Requirements
- R1: The framing word is 0xF6, 0xF6, 0xF6, 0x28, 0x28, 0x28, compared most significant bit first in arrival order. Only this 48-bit sequence counts as a match.
- R2: After reset, `byte_offset` is 7, and `byte_strobe` and `frame_pulse` are 0.
- R3: Until the first rising edge of `oof` after reset, a framing word causes no realignment and no frame pulse.
- R4: A rising edge on `oof` arms the search. While armed, a match ending on bit index k (0-based, counting enabled bits since reset) sets `byte_offset` to k mod 8. In the cycle after that bit, `byte_strobe` and `frame_pulse` rise together.
- R5: The search stays armed while `oof` is high, so later matches at other offsets realign again.
- R6: The search is disarmed once a match has been found and `oof` is low. While disarmed, a match not ending on the locked boundary leaves `byte_offset` unchanged and raises no frame pulse. If `oof` is pulsed and returns low before any match, the search stays armed until the first match.
- R7: While disarmed, a match whose last bit has index k with k mod 8 equal to `byte_offset` raises `frame_pulse` together with `byte_strobe`.
- R8: `byte_strobe` is a one-cycle pulse in the cycle after each enabled bit whose index mod 8 equals `byte_offset`. It never follows a cycle with `bit_en` low.
- R9: `frame_pulse` changes only in cycles where `byte_strobe` is high, so it lasts exactly one byte period of 8 enabled bits.
- R10: When `loop_en` is 1, `loop_bit` is aligned and `rx_bit` is ignored. When `loop_en` is 0, `rx_bit` is used.
- R11: In cycles where `bit_en` is 0, no bit is consumed: no strobe, and no change to the offset or the frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bit-rate enable; one serial bit is taken when high |
| rx_bit | input | 1 | Line serial data |
| loop_bit | input | 1 | Loopback serial data |
| loop_en | input | 1 | Selects loopback data over line data |
| oof | input | 1 | Out-of-frame control; rising edge arms the search |
| byte_offset | output | 3 | Bit phase of the locked byte boundary |
| byte_strobe | output | 1 | One-cycle pulse after each byte's last bit |
| frame_pulse | output | 1 | Byte-wide pulse after a framing word's last bit |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, three A1 and three A2 bytes, and the loopback variant selected. With these values, a vector walk with varied amounts of filler moves the locked boundary across many bit phases, in both the line and the loopback source. The short byte makes a full frame-pulse width observable within eight enabled bits. Directed tests cover the time before arming, the frozen state with aligned and misaligned words, an `oof` pulse that ends before any match, and long stretches with the bit enable held low.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
   typedef enum logic {
      SRC_LINE = 1'b0,
      SRC_LOOP = 1'b1
   } sfa_src_e;

   function automatic int unsigned sfa_pat_w(input int unsigned bw,
                                             input int unsigned n1,
                                             input int unsigned n2);
      return bw * (n1 + n2);
   endfunction
endpackage

// File: rtl/sfa_src_sel.sv
module sfa_src_sel
   import sfa_pkg::*;
#(
   parameter bit HAS_LOOP = 1'b1
) (
   input  logic     rx_bit,
   input  logic     loop_bit,
   input  logic     loop_en,
   output logic     sel_bit,
   output sfa_src_e src
);
   generate
      if (HAS_LOOP) begin : g_loop
         assign src     = loop_en ? SRC_LOOP : SRC_LINE;
         assign sel_bit = (src == SRC_LOOP) ? loop_bit : rx_bit;
      end else begin : g_line_only
         logic unused_loop;
         assign unused_loop = loop_bit ^ loop_en;
         assign src         = SRC_LINE;
         assign sel_bit     = rx_bit;
      end
   endgenerate
endmodule

// File: rtl/sfa_pattern_det.sv
module sfa_pattern_det
   import sfa_pkg::*;
#(
   parameter int unsigned       BYTE_W  = 8,
   parameter int unsigned       N_A1    = 3,
   parameter int unsigned       N_A2    = 3,
   parameter logic [BYTE_W-1:0] A1_CODE = 8'hF6,
   parameter logic [BYTE_W-1:0] A2_CODE = 8'h28
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic din,
   output logic match_now
);
   localparam int unsigned N_BYTES = N_A1 + N_A2;
   localparam int unsigned PAT_W   = sfa_pat_w(BYTE_W, N_A1, N_A2);

   logic [PAT_W-1:0] pattern;
   logic [PAT_W-1:0] window_q;
   logic [PAT_W-1:0] window_nxt;

   genvar g;
   generate
      for (g = 0; g < N_BYTES; g++) begin : g_pat
         if (g < N_A1) begin : g_a1
            assign pattern[PAT_W-1-g*BYTE_W -: BYTE_W] = A1_CODE;
         end else begin : g_a2
            assign pattern[PAT_W-1-g*BYTE_W -: BYTE_W] = A2_CODE;
         end
      end
   endgenerate

   assign window_nxt = {window_q[PAT_W-2:0], din};
   assign match_now  = (window_nxt == pattern);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         window_q <= '0;
      end else if (bit_en) begin
         window_q <= window_nxt;
      end
   end

   // R11
   window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(window_q));
endmodule

// File: rtl/sfa_arm_ctrl.sv
module sfa_arm_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic oof,
   input  logic hit,
   output logic armed,
   output logic primed
);
   logic oof_q;
   logic found_q;
   logic oof_rise;

   assign oof_rise = oof & ~oof_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oof_q   <= 1'b0;
         armed   <= 1'b0;
         found_q <= 1'b0;
         primed  <= 1'b0;
      end else begin
         oof_q <= oof;
         if (oof_rise) begin
            armed   <= 1'b1;
            found_q <= 1'b0;
            primed  <= 1'b1;
         end else if (armed) begin
            if (hit) found_q <= 1'b1;
            if (!oof && (found_q || hit)) armed <= 1'b0;
         end
      end
   end

   // R4
   arm_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oof && !oof_q) |=> armed);
   // R5
   arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && oof) |=> armed);
   // R6
   disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !oof && !oof_q && found_q) |=> !armed);
   // R3
   armed_primed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> primed);
endmodule

// File: rtl/sfa_byte_timer.sv
module sfa_byte_timer #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned OFF_W = $clog2(BYTE_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             realign,
   input  logic             match_now,
   input  logic             primed,
   output logic [OFF_W-1:0] offset,
   output logic             strobe,
   output logic             frame
);
   localparam logic [OFF_W-1:0] LAST = OFF_W'(BYTE_W - 1);

   logic [OFF_W-1:0] phase_q;
   logic             byte_done;

   assign byte_done = bit_en && (realign || (phase_q == offset));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         offset  <= LAST;
         strobe  <= 1'b0;
         frame   <= 1'b0;
      end else begin
         strobe <= byte_done;
         if (bit_en) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
            if (realign) offset <= phase_q;
         end
         if (byte_done) frame <= primed && match_now;
      end
   end

   // R8
   strobe_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> $past(bit_en));
   // R9
   frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |-> $stable(frame));
   // R11
   offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(offset));
endmodule

// File: rtl/sonet_frame_aligner.sv
module sonet_frame_aligner
   import sfa_pkg::*;
#(
   parameter int unsigned       BYTE_W   = 8,
   parameter int unsigned       N_A1     = 3,
   parameter int unsigned       N_A2     = 3,
   parameter logic [BYTE_W-1:0] A1_CODE  = 8'hF6,
   parameter logic [BYTE_W-1:0] A2_CODE  = 8'h28,
   parameter bit                HAS_LOOP = 1'b1,
   localparam int unsigned      OFF_W    = $clog2(BYTE_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             rx_bit,
   input  logic             loop_bit,
   input  logic             loop_en,
   input  logic             oof,
   output logic [OFF_W-1:0] byte_offset,
   output logic             byte_strobe,
   output logic             frame_pulse
);
   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("BYTE_W must be at least 2");
      end
      if (N_A1 < 1 || N_A2 < 1) begin : g_bad_count
         $error("N_A1 and N_A2 must be at least 1");
      end
   endgenerate

   logic     sel_bit;
   sfa_src_e src;
   logic     match_now;
   logic     armed;
   logic     primed;
   logic     realign;

   sfa_src_sel #(.HAS_LOOP(HAS_LOOP)) u_src (
      .rx_bit  (rx_bit),
      .loop_bit(loop_bit),
      .loop_en (loop_en),
      .sel_bit (sel_bit),
      .src     (src)
   );

   sfa_pattern_det #(
      .BYTE_W (BYTE_W),
      .N_A1   (N_A1),
      .N_A2   (N_A2),
      .A1_CODE(A1_CODE),
      .A2_CODE(A2_CODE)
   ) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .din      (sel_bit),
      .match_now(match_now)
   );

   assign realign = armed && bit_en && match_now;

   sfa_arm_ctrl u_arm (
      .clk   (clk),
      .rst_n (rst_n),
      .oof   (oof),
      .hit   (realign),
      .armed (armed),
      .primed(primed)
   );

   sfa_byte_timer #(.BYTE_W(BYTE_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .realign  (realign),
      .match_now(match_now),
      .primed   (primed),
      .offset   (byte_offset),
      .strobe   (byte_strobe),
      .frame    (frame_pulse)
   );

   // R10
   src_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_LOOP && loop_en) |-> (src == SRC_LOOP));
   // R3
   no_frame_unprimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !primed |-> !frame_pulse);
   // R6
   offset_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(byte_offset) |-> $past(armed));
   // R9
   frame_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_pulse) |-> byte_strobe);
endmodule

// File: tb/sonet_frame_aligner_test.sv
module sonet_frame_aligner_test;
   localparam int CLK_P = 10;
   localparam logic [47:0] PAT = {8'hF6, 8'hF6, 8'hF6, 8'h28, 8'h28, 8'h28};
   // bit 3: use loopback source, bits 2:0: extra filler bits
   localparam logic [3:0] VEC [6] = '{4'b0011, 4'b1000, 4'b0101, 4'b1001, 4'b0111, 4'b0010};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0, rx_bit = 1'b0, loop_bit = 1'b0, loop_en = 1'b0, oof = 1'b0;
   logic [2:0] byte_offset;
   logic byte_strobe, frame_pulse;

   int checks = 0, errors = 0;
   int idx = 0;
   int exp_off = 7;
   logic obs_stb, obs_fp;
   logic [2:0] obs_off;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   sonet_frame_aligner uut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
      .loop_bit(loop_bit), .loop_en(loop_en), .oof(oof),
      .byte_offset(byte_offset), .byte_strobe(byte_strobe), .frame_pulse(frame_pulse)
   );

   task automatic chk(input bit ok, input string tag, input int got, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic send_bit(input logic rb, input logic lb, input logic le);
      @(negedge clk);
      rx_bit = rb; loop_bit = lb; loop_en = le; bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      obs_stb = byte_strobe; obs_fp = frame_pulse; obs_off = byte_offset;
      chk(obs_stb == ((idx % 8) == exp_off), "R8 strobe cadence", obs_stb, (idx % 8) == exp_off);
      idx++;
      @(negedge clk);
      chk(byte_strobe == 1'b0, "R11 no strobe while bit_en low", byte_strobe, 0);
   endtask

   task automatic send_line(input logic b);
      send_bit(b, ~b, 1'b0);
   endtask

   task automatic filler(input int n);
      for (int i = 0; i < n; i++) send_line(1'b0);
   endtask

   // use_loop: pattern on loop_bit; rx_only_pat: pattern on rx while loopback selected
   task automatic send_pat(input bit realign, input bit use_loop, input bit rx_only_pat);
      for (int i = 0; i < 48; i++) begin
         if (i == 47 && realign) exp_off = idx % 8;
         if (rx_only_pat) send_bit(PAT[47-i], 1'b0, 1'b1);
         else if (use_loop) send_bit(~PAT[47-i], PAT[47-i], 1'b1);
         else send_line(PAT[47-i]);
      end
   endtask

   task automatic tail_byte(input string tag);
      for (int j = 0; j < 8; j++) begin
         send_line(1'b0);
         if (j < 7) chk(obs_fp == 1'b1, tag, obs_fp, 1);
         else chk(obs_fp == 1'b0 && obs_stb == 1'b1, tag, obs_fp, 0);
      end
   endtask

   function automatic int align_fill();
      return (((exp_off - (idx + 47)) % 8) + 8) % 8;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got %0d expected %0d", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk(byte_offset == 3'd7, "R2 reset offset", byte_offset, 7);
      chk(byte_strobe == 1'b0, "R2 reset strobe", byte_strobe, 0);
      chk(frame_pulse == 1'b0, "R2 reset frame", frame_pulse, 0);

      // R3 no alignment before first oof rise
      filler(2);
      send_pat(1'b0, 1'b0, 1'b0);
      chk(obs_fp == 1'b0, "R3 no frame before arming", obs_fp, 0);
      chk(obs_off == 3'd7, "R3 offset unchanged before arming", obs_off, 7);
      filler(8);

      // R4 arm
      @(negedge clk); oof = 1'b1; @(negedge clk);

      // R4 R5 R1 R10 R9 vector walk with oof held high
      foreach (VEC[v]) begin
         filler(3 + VEC[v][2:0]);
         send_pat(1'b1, VEC[v][3], 1'b0);
         chk(obs_off == exp_off[2:0], "R4 R5 realigned offset", obs_off, exp_off);
         chk(obs_stb && obs_fp, "R4 frame with strobe", obs_fp, 1);
         tail_byte("R9 frame one byte wide");
      end

      // R10 line stream ignored while loopback selected
      filler(5);
      send_pat(1'b0, 1'b0, 1'b1);
      chk(obs_fp == 1'b0, "R10 rx ignored in loopback", obs_fp, 0);
      chk(obs_off == exp_off[2:0], "R10 offset kept in loopback", obs_off, exp_off);

      // R1 near-miss word (last bit flipped) is not a match
      filler(4);
      for (int i = 0; i < 48; i++) send_line(i == 47 ? ~PAT[0] : PAT[47-i]);
      chk(obs_fp == 1'b0, "R1 near miss ignored", obs_fp, 0);
      chk(obs_off == exp_off[2:0], "R1 near miss offset", obs_off, exp_off);

      // R6 disarm and freeze
      @(negedge clk); oof = 1'b0; @(negedge clk);
      filler(align_fill() + 3);
      send_pat(1'b0, 1'b0, 1'b0);
      chk(obs_fp == 1'b0, "R6 misaligned frozen no frame", obs_fp, 0);
      chk(obs_off == exp_off[2:0], "R6 offset frozen", obs_off, exp_off);

      // R7 aligned word while frozen
      filler(align_fill() + 8);
      send_pat(1'b0, 1'b0, 1'b0);
      chk(obs_fp == 1'b1 && obs_stb == 1'b1, "R7 aligned frozen frame", obs_fp, 1);
      chk(obs_off == exp_off[2:0], "R7 offset kept", obs_off, exp_off);
      tail_byte("R9 frozen frame width");

      // R11 idle enable
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         rx_bit = c[0]; loop_bit = c[1]; loop_en = c[2];
         chk(byte_strobe == 1'b0 && byte_offset == exp_off[2:0] && frame_pulse == 1'b0,
             "R11 idle holds state", byte_offset, exp_off);
      end

      // R6 oof pulse ends before match: stays armed until first match
      @(negedge clk); oof = 1'b1; @(negedge clk); oof = 1'b0;
      filler(align_fill() + 5);
      send_pat(1'b1, 1'b0, 1'b0);
      chk(obs_off == exp_off[2:0] && obs_fp == 1'b1, "R6 armed until first match", obs_off, exp_off);
      tail_byte("R9 frame width after pulse");
      filler(align_fill() + 2);
      send_pat(1'b0, 1'b0, 1'b0);
      chk(obs_fp == 1'b0 && obs_off == exp_off[2:0], "R6 disarmed after match", obs_off, exp_off);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule